// File: doc/BRIEF.md
# LCD Frame Sequencer

This block sequences the work of a panel display controller. Software writes a control word that holds a run bit, a two-bit load-mode field, a line number for the line interrupt and one interrupt mask bit per status source. When the run bit is set, the sequencer asks an upstream fetch engine for a colour-table load, for frames of pixel words, or for both in turn. In frame work it asks again at the start of every frame for as long as the run bit stays set. Fetched pixel words pass through a small first-word-fall-through FIFO. They are handed to the panel side one per pixel strobe.

Stopping is graceful. When the run bit is cleared in the middle of a frame, that frame is still fetched and shown in full. The sequencer then goes idle and raises a sticky completion flag. Status flags report completion, colour-table loaded, end of frame, AC-bias period, the selected line, FIFO starvation and loss of panel sync. A single interrupt line combines the flags through their masks.

The fetch side uses two valid/ready handshakes. A request beat carries a kind bit (colour table or frame). The upstream side must then send exactly `PAL_WORDS` or `H_PIX*V_LINES` words. A beat moves only on a cycle where both valid and ready are high. The request valid stays high until accepted, unless the run bit is cleared. The data ready goes low whenever the FIFO is full or the frame's word count has been accepted.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset every status bit is 0, `irq` is 0, and neither `fetch_req_valid` nor `fetch_dat_ready` is high.
- R2: The load mode sits at control bits 21:20. With 00, starting issues a colour-table request (`fetch_req_pal`=1) of `PAL_WORDS` words first, then frame requests; status bit 1 (table loaded) sets when the last table word is taken.
- R3: With mode 01, only one colour-table request is issued and no frame request follows. Status bit 1 sets at the end of the table, and in this mode a status write with bit 1 high clears it.
- R4: With mode 10 (11 acts the same), the first request is a frame request. Each frame takes `H_PIX*V_LINES` words, and pixels leave on `pix_data` in arrival order. A new frame request follows every frame while the run bit (control bit 0) is set.
- R5: Clearing the run bit mid-frame lets that frame finish in full. Then status bit 0 (done) sets and no further request is issued.
- R6: Done stays set through status writes. It clears only when the run bit goes from 0 to 1.
- R7: In modes other than 01, a status write does not clear bit 1. Clearing the run bit clears it in every mode.
- R8: A pixel strobe while a frame is running, the run bit is set and the FIFO is empty sets status bit 5, and no pixel is consumed. Bit 5 clears only when the run bit is cleared.
- R9: `sync_err` high while the run bit is set sets status bit 6. Bit 6 clears only when the run bit is cleared.
- R10: Bit 2 sets at every frame end. Bit 4 sets when the line numbered by control bits 15:8 finishes. Bit 3 sets every `ACB_LINES` finished lines. All three clear on a status write with a 1 in their position.
- R11: `irq` is high exactly when some status bit i is set together with mask bit i, held in control bit i+1.
- R12: `fetch_req_valid` holds with a stable kind bit until accepted, unless the run bit is being cleared. `fetch_dat_ready` is low while the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: run bit 0, masks 7:1, line 15:8, mode 21:20 |
| stat_we | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 7 | Status write data |
| status | output | 7 | Status flags |
| irq | output | 1 | Masked interrupt |
| fetch_req_valid | output | 1 | Fetch request valid |
| fetch_req_ready | input | 1 | Fetch request ready |
| fetch_req_pal | output | 1 | Request kind: 1 colour table, 0 frame |
| fetch_dat_valid | input | 1 | Fetched word valid |
| fetch_dat_ready | output | 1 | Fetched word ready |
| fetch_dat | input | DATA_W | Fetched word |
| pix_tick | input | 1 | Panel pixel strobe |
| sync_err | input | 1 | Panel sync lost indication |
| pix_valid | output | 1 | Pixel handed to panel this cycle |
| pix_data | output | DATA_W | Pixel word |

## Verification
The assertions assume the upstream side keeps its contract. It sends exactly the word count of the request it accepted, and only after that request. They also assume the panel strobe and sync indication are plain single-cycle levels. The bench stub answers every request at once and streams exactly the right number of words, with random gaps and a stall switch. Pixel strobes come at a random rate with a fixed seed, and the run bit is only toggled through whole control writes, so every started frame can complete.

// File: rtl/lcdseq_pkg.sv
`timescale 1ns/1ps
package lcdseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PREQ, S_PDATA, S_PHOLD, S_FREQ, S_FRAME
  } seq_state_t;

  localparam int ST_W     = 7;
  localparam int ST_DONE  = 0;
  localparam int ST_PAL   = 1;
  localparam int ST_VSYNC = 2;
  localparam int ST_ACB   = 3;
  localparam int ST_LINE  = 4;
  localparam int ST_UFLOW = 5;
  localparam int ST_SYNC  = 6;

  localparam logic [1:0] MODE_PAL_FRAME  = 2'b00;
  localparam logic [1:0] MODE_PAL_ONLY   = 2'b01;
  localparam logic [1:0] MODE_FRAME_ONLY = 2'b10;
endpackage

// File: rtl/lcdseq_fifo.sv
`timescale 1ns/1ps
module lcdseq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R12: the fetch side never writes into a full FIFO
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: the panel side never reads from an empty FIFO
  a_r8_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lcdseq_timing.sv
`timescale 1ns/1ps
module lcdseq_timing #(
  parameter int H_PIX     = 8,
  parameter int V_LINES   = 4,
  parameter int ACB_LINES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       en,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic [7:0] line_sel,
  output logic       pop,
  output logic       frame_end,
  output logic       line_ev,
  output logic       acb_ev,
  output logic       uflow_ev
);
  localparam int CW = (H_PIX > 1) ? $clog2(H_PIX) : 1;
  localparam int RW = (V_LINES > 1) ? $clog2(V_LINES) : 1;
  localparam int AW = (ACB_LINES > 1) ? $clog2(ACB_LINES) : 1;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] acb_cnt;
  logic          line_last;

  assign pop       = run && tick && !fifo_empty;
  assign uflow_ev  = run && en && tick && fifo_empty;
  assign line_last = pop && (col == CW'(H_PIX-1));
  assign frame_end = line_last && (row == RW'(V_LINES-1));
  assign line_ev   = line_last && (8'(row) == line_sel);
  assign acb_ev    = line_last && (acb_cnt == AW'(ACB_LINES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (!run) begin
      col <= '0;
      row <= '0;
    end else if (pop) begin
      if (line_last) begin
        col <= '0;
        row <= frame_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acb_cnt <= '0;
    else if (acb_ev)  acb_cnt <= '0;
    else if (line_last) acb_cnt <= acb_cnt + 1'b1;
  end
endmodule

// File: rtl/lcdseq_status.sv
`timescale 1ns/1ps
module lcdseq_status #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] hw_clr,
  input  logic [N-1:0] w1c_ok,
  input  logic         stat_we,
  input  logic [N-1:0] stat_wdata,
  input  logic [N-1:0] mask,
  output logic [N-1:0] st_q,
  output logic         irq
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  st_q[b] <= 1'b0;
      else if (hw_clr[b])                          st_q[b] <= 1'b0;
      else if (set_ev[b])                          st_q[b] <= 1'b1;
      else if (stat_we && stat_wdata[b] && w1c_ok[b]) st_q[b] <= 1'b0;
    end
  end

  assign irq = |(st_q & mask);

  // R6: the completion flag only drops on its hardware clear
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[0] && !hw_clr[0] |=> st_q[0]);
endmodule

// File: rtl/lcd_frame_seq.sv
`timescale 1ns/1ps
module lcd_frame_seq
  import lcdseq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int H_PIX      = 8,
  parameter int V_LINES    = 4,
  parameter int PAL_WORDS  = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int ACB_LINES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  input  logic              stat_we,
  input  logic [6:0]        stat_wdata,
  output logic [6:0]        status,
  output logic              irq,
  output logic              fetch_req_valid,
  input  logic              fetch_req_ready,
  output logic              fetch_req_pal,
  input  logic              fetch_dat_valid,
  output logic              fetch_dat_ready,
  input  logic [DATA_W-1:0] fetch_dat,
  input  logic              pix_tick,
  input  logic              sync_err,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data
);
  localparam int FRAME_WORDS = H_PIX * V_LINES;
  localparam int FCW = $clog2(FRAME_WORDS + 1);
  localparam int PCW = $clog2(PAL_WORDS + 1);

  seq_state_t state, nxt;

  logic            en_q;
  logic [6:0]      mask_q;
  logic [7:0]      line_q;
  logic [1:0]      mode_q, mode_run;
  logic [PCW-1:0]  pal_cnt;
  logic [FCW-1:0]  frm_acc;
  logic            en_rise, en_fall;
  logic            ctrl_unused;
  logic            fifo_empty, fifo_full, push, pop;
  logic            pal_last, frame_end, line_ev, acb_ev, uflow_ev, done_ev;
  logic [ST_W-1:0] set_ev, hw_clr, w1c_ok;

  assign ctrl_unused = ^{ctrl_wdata[31:22], ctrl_wdata[19:16]};
  assign en_rise = ctrl_we && ctrl_wdata[0] && !en_q;
  assign en_fall = ctrl_we && !ctrl_wdata[0] && en_q;

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      line_q <= '0;
      mode_q <= MODE_PAL_FRAME;
    end else if (ctrl_we) begin
      en_q   <= ctrl_wdata[0];
      mask_q <= ctrl_wdata[7:1];
      line_q <= ctrl_wdata[15:8];
      mode_q <= ctrl_wdata[21:20];
    end
  end

  // fetch handshakes
  assign fetch_req_valid = en_q && (state == S_PREQ || state == S_FREQ);
  assign fetch_req_pal   = (state == S_PREQ);
  always_comb begin
    case (state)
      S_PDATA: fetch_dat_ready = 1'b1;
      S_FRAME: fetch_dat_ready = !fifo_full && (frm_acc < FCW'(FRAME_WORDS));
      default: fetch_dat_ready = 1'b0;
    endcase
  end
  assign push     = (state == S_FRAME) && fetch_dat_valid && fetch_dat_ready;
  assign pal_last = (state == S_PDATA) && fetch_dat_valid &&
                    (pal_cnt == PCW'(PAL_WORDS - 1));

  // sequencer
  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:
        if (en_q)
          nxt = (mode_q == MODE_PAL_FRAME || mode_q == MODE_PAL_ONLY) ? S_PREQ : S_FREQ;
      S_PREQ:
        if (!en_q) nxt = S_IDLE;
        else if (fetch_req_ready) nxt = S_PDATA;
      S_PDATA:
        if (pal_last)
          nxt = !en_q ? S_IDLE : ((mode_run == MODE_PAL_ONLY) ? S_PHOLD : S_FREQ);
      S_PHOLD:
        if (!en_q) nxt = S_IDLE;
      S_FREQ:
        if (!en_q) nxt = S_IDLE;
        else if (fetch_req_ready) nxt = S_FRAME;
      S_FRAME:
        if (frame_end) nxt = en_q ? S_FREQ : S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end
  assign done_ev = (state != S_IDLE) && (nxt == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_run <= MODE_PAL_FRAME;
      pal_cnt  <= '0;
      frm_acc  <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE) mode_run <= mode_q;
      if (state == S_PREQ) pal_cnt <= '0;
      else if (state == S_PDATA && fetch_dat_valid) pal_cnt <= pal_cnt + 1'b1;
      if (state == S_FREQ) frm_acc <= '0;
      else if (push) frm_acc <= frm_acc + 1'b1;
    end
  end

  lcdseq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(fetch_dat), .pop(pop),
    .dout(pix_data), .empty(fifo_empty), .full(fifo_full)
  );

  lcdseq_timing #(.H_PIX(H_PIX), .V_LINES(V_LINES), .ACB_LINES(ACB_LINES)) u_timing (
    .clk(clk), .rst_n(rst_n), .run(state == S_FRAME), .en(en_q), .tick(pix_tick),
    .fifo_empty(fifo_empty), .line_sel(line_q), .pop(pop), .frame_end(frame_end),
    .line_ev(line_ev), .acb_ev(acb_ev), .uflow_ev(uflow_ev)
  );
  assign pix_valid = pop;

  // status sources and clear rules
  always_comb begin
    set_ev = '0;
    set_ev[ST_DONE]  = done_ev;
    set_ev[ST_PAL]   = pal_last;
    set_ev[ST_VSYNC] = frame_end;
    set_ev[ST_ACB]   = acb_ev;
    set_ev[ST_LINE]  = line_ev;
    set_ev[ST_UFLOW] = uflow_ev;
    set_ev[ST_SYNC]  = sync_err && en_q;
    hw_clr = '0;
    hw_clr[ST_DONE]  = en_rise;
    hw_clr[ST_PAL]   = en_fall;
    hw_clr[ST_UFLOW] = en_fall;
    hw_clr[ST_SYNC]  = en_fall;
    w1c_ok = '0;
    w1c_ok[ST_PAL]   = (mode_q == MODE_PAL_ONLY);
    w1c_ok[ST_VSYNC] = 1'b1;
    w1c_ok[ST_ACB]   = 1'b1;
    w1c_ok[ST_LINE]  = 1'b1;
  end

  lcdseq_status #(.N(ST_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .hw_clr(hw_clr), .w1c_ok(w1c_ok),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .mask(mask_q),
    .st_q(status), .irq(irq)
  );

  // R12: a pending request is held with its kind until taken
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid && !fetch_req_ready && !(ctrl_we && !ctrl_wdata[0])
    |=> fetch_req_valid && $stable(fetch_req_pal));
  // R5: completion is flagged only as the sequencer reaches idle
  a_r5_done_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_DONE]) |-> (state == S_IDLE));
  // R8: a starvation flag is raised by a strobe that delivered no pixel
  a_r8_uflow_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_UFLOW]) |-> $past(!pix_valid));
  // R3: a colour-table-only run never asks for frame data
  a_r3_pal_only_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid && (state != S_IDLE) && (mode_run == MODE_PAL_ONLY) |-> fetch_req_pal);
endmodule

// File: tb/lcd_frame_seq_bench.sv
`timescale 1ns/1ps
module lcd_frame_seq_bench;
  localparam int DW = 16, HP = 8, VL = 4, PW = 8, FD = 4, AL = 3;
  localparam int FRAME = HP * VL;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0; logic [31:0] ctrl_wdata = '0;
  logic stat_we = 0; logic [6:0] stat_wdata = '0;
  logic [6:0] status; logic irq;
  logic fetch_req_valid, fetch_req_ready = 0, fetch_req_pal;
  logic fetch_dat_valid = 0, fetch_dat_ready; logic [DW-1:0] fetch_dat = '0;
  logic pix_tick = 0, sync_err = 0, pix_valid; logic [DW-1:0] pix_data;

  lcd_frame_seq #(.DATA_W(DW), .H_PIX(HP), .V_LINES(VL), .PAL_WORDS(PW),
                  .FIFO_DEPTH(FD), .ACB_LINES(AL)) u_lcd_frame_seq (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int pal_reqs = 0, frame_reqs = 0, req_total = 0;
  bit req_kind [0:3];
  int frm_id = 0, exp_frm = 0, exp_idx = 0, pix_cnt = 0, pix_err = 0;
  bit stall = 0, tick_on = 0; int tick_pct = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit en, logic [1:0] mode, logic [6:0] msk, logic [7:0] ln);
    logic [31:0] d = '0;
    d[0] = en; d[7:1] = msk; d[15:8] = ln; d[21:20] = mode;
    return d;
  endfunction

  function automatic logic [DW-1:0] exp_word(int f, int i);
    return {f[7:0], i[7:0]};
  endfunction

  task automatic wr_ctrl(logic [31:0] d);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_stat(logic [6:0] d);
    @(negedge clk); stat_we = 1; stat_wdata = d;
    @(negedge clk); stat_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_bit(int b, int maxc, output bit seen);
    seen = 0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (status[b]) begin seen = 1; break; end
    end
  endtask

  // upstream fetch stub
  initial begin
    bit is_pal, hs; int n, i;
    forever begin
      @(negedge clk);
      if (fetch_req_valid) begin
        is_pal = fetch_req_pal;
        fetch_req_ready = 1;
        @(negedge clk);
        fetch_req_ready = 0;
        if (req_total < 4) req_kind[req_total] = is_pal;
        req_total++;
        if (is_pal) pal_reqs++; else frame_reqs++;
        n = is_pal ? PW : FRAME; i = 0;
        while (i < n) begin
          if (!stall && $urandom_range(0, 3) != 0) begin
            fetch_dat_valid = 1;
            fetch_dat = is_pal ? DW'(16'hA000 + i) : exp_word(frm_id, i);
          end else fetch_dat_valid = 0;
          #1 hs = fetch_dat_valid && fetch_dat_ready;
          @(negedge clk);
          if (hs) i++;
        end
        fetch_dat_valid = 0;
        if (!is_pal) frm_id++;
      end
    end
  end

  // panel strobe and pixel monitor
  initial begin
    forever begin
      @(negedge clk);
      pix_tick = tick_on && ($urandom_range(0, 99) < tick_pct);
      #1;
      if (pix_valid) begin
        if (pix_data !== exp_word(exp_frm, exp_idx)) pix_err++;
        pix_cnt++; exp_idx++;
        if (exp_idx == FRAME) begin exp_idx = 0; exp_frm++; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen; int a, b, c;
    void'($urandom(32'd20240611));
    idle(5); rst_n = 1; idle(2);
    // R1 reset state
    chk(status == 0, "R1 status after reset", status, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(fetch_req_valid == 0 && fetch_dat_ready == 0, "R1 no handshake", fetch_req_valid, 0);

    // R2 palette then frames
    tick_on = 1; tick_pct = 60;
    wr_ctrl(mk(1, 2'b00, 7'h00, 8'd1));
    for (int k = 0; k < 3000 && frame_reqs < 2; k++) @(negedge clk);
    chk(req_kind[0] == 1 && req_kind[1] == 0, "R2 table request first", req_kind[0], 1);
    chk(pal_reqs == 1, "R2 one table request", pal_reqs, 1);
    chk(status[1] == 1, "R2 table loaded flag", status[1], 1);
    chk(status[2] == 1, "R10 vsync flag", status[2], 1);
    chk(status[4] == 1, "R10 line flag", status[4], 1);
    chk(status[3] == 1, "R10 acb flag", status[3], 1);
    wr_stat(7'h02);
    chk(status[1] == 1, "R7 table flag kept in mode 00", status[1], 1);
    // R5 graceful stop
    wr_ctrl(mk(0, 2'b00, 7'h00, 8'd1));
    wait_bit(0, 3000, seen);
    chk(seen, "R5 done after stop", seen, 1);
    chk(pix_err == 0 && (pix_cnt % FRAME) == 0, "R5 whole frames shown", pix_cnt % FRAME, 0);
    chk(exp_frm == frm_id, "R4 all fetched frames shown", exp_frm, frm_id);
    chk(status[1] == 0, "R7 table flag cleared by stop", status[1], 0);
    a = req_total; idle(40);
    chk(req_total == a, "R5 no request after done", req_total, a);
    wr_stat(7'h7F);
    chk(status[2] == 0 && status[3] == 0 && status[4] == 0, "R10 write-one-to-clear", status, 1);
    chk(status[0] == 1, "R6 done survives status write", status[0], 1);

    // R11 masking
    wr_ctrl(mk(0, 2'b00, 7'h01, 8'd0));
    chk(irq == 1, "R11 irq with done masked in", irq, 1);
    wr_ctrl(mk(0, 2'b00, 7'h04, 8'd0));
    chk(irq == 0, "R11 irq with done masked out", irq, 0);

    // R3 table only
    a = frame_reqs; b = pal_reqs;
    wr_ctrl(mk(1, 2'b01, 7'h00, 8'd0));
    chk(status[0] == 0, "R6 done cleared on start", status[0], 0);
    wait_bit(1, 500, seen);
    idle(40);
    chk(seen && pal_reqs == b + 1, "R3 single table request", pal_reqs, b + 1);
    chk(frame_reqs == a, "R3 no frame request", frame_reqs, a);
    wr_stat(7'h02);
    chk(status[1] == 0, "R3 table flag cleared by write", status[1], 0);
    wr_ctrl(mk(0, 2'b01, 7'h00, 8'd0));
    wait_bit(0, 100, seen);
    chk(seen, "R5 done after table-only stop", seen, 1);

    // R4 / R12 frame only, FIFO back-pressure
    tick_on = 0; a = frame_reqs; b = pal_reqs; c = pix_cnt;
    wr_ctrl(mk(1, 2'b10, 7'h00, 8'd0));
    idle(40);
    chk(frame_reqs == a + 1 && pal_reqs == b, "R4 frame request first", frame_reqs, a + 1);
    chk(fetch_dat_ready == 0, "R12 ready low when FIFO full", fetch_dat_ready, 0);
    chk(status[5] == 0, "R8 no starvation yet", status[5], 0);
    // R8 starvation
    stall = 1; idle(3);
    tick_on = 1; tick_pct = 100; idle(12);
    tick_on = 0; idle(1);
    chk(pix_cnt == c + FD, "R8 empty strobe consumes nothing", pix_cnt - c, FD);
    chk(status[5] == 1, "R8 starvation flag", status[5], 1);
    wr_stat(7'h20);
    chk(status[5] == 1, "R8 flag not write-cleared", status[5], 1);
    // R9 sync loss
    @(negedge clk); sync_err = 1; @(negedge clk); sync_err = 0;
    chk(status[6] == 1, "R9 sync flag", status[6], 1);
    stall = 0; tick_on = 1; tick_pct = 50;
    wr_ctrl(mk(0, 2'b10, 7'h00, 8'd0));
    chk(status[5] == 0 && status[6] == 0, "R8 R9 cleared by stop", status[6:5], 0);
    wait_bit(0, 3000, seen);
    chk(seen && pix_err == 0 && exp_frm == frm_id, "R5 frame completes after starvation", exp_frm, frm_id);

    // random runs
    for (int it = 0; it < 12; it++) begin
      logic [1:0] md;
      case ($urandom_range(0, 2)) 0: md = 2'b00; 1: md = 2'b10; default: md = 2'b11; endcase
      tick_pct = $urandom_range(30, 95);
      wr_ctrl(mk(1, md, 7'h00, 8'($urandom_range(0, VL - 1))));
      idle($urandom_range(50, 300));
      wr_ctrl(mk(0, md, 7'h00, 8'd0));
      wait_bit(0, 3000, seen);
      chk(seen && pix_err == 0 && (pix_cnt % FRAME) == 0 && exp_frm == frm_id,
          "R4 R5 random run order and completion", pix_err, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule